// File: doc/BRIEF.md
# Debounced Level Interrupt Bank

This block watches eight external input pins and turns each into a level-sensitive interrupt source. Each pin passes through a two-stage synchronizer. A per-channel filter then accepts a new level only after the pin has held it for a programmable number of 1 ms ticks. The filtered levels can be read back. Each is compared with a per-channel polarity bit. When a channel is armed and its filtered level matches its polarity, its raw status bit is set and its arm bit drops.

Software reaches the bank through a flat 32-bit register port with an address, a write strobe, write data and combinational read data. A single interrupt line is the OR of the raw status bits that are also enabled. An interrupt handler acknowledges a source by writing one to the clear register and re-arms it when it wants the next event.

Top module: `lib_bank`

## Requirements
- R1: After reset, every register reads zero except each channel's window word, which reads 1. irq_o is low, and bits above 7 of every 8-bit register read as zero.
- R2: With sampling enabled, the filtered level of channel c, at bit c of offset 0x00, takes a new pin level on the tick that completes the programmed number of consecutive ticks at that level, and not before.
- R3: If the pin returns to the filtered level before the window completes, the count restarts, and the new level then needs a full window of ticks.
- R4: While bit c of the sample-enable register (offset 0x04) is 0, pin changes and ticks leave channel c's filtered level unchanged.
- R5: The window word of channel c lies at offset 0x40 + 4*c. Bits 11:0 are stored, upper bits read as zero, and a value of 0 acts as a one-tick window.
- R6: Polarity bit c (offset 0x14) set to 1 fires on a filtered high, and 0 fires on a filtered low. The raw status (offset 0x1C) bit is set in the cycle after an armed channel matches.
- R7: Arm bit c (offset 0x28) clears itself when channel c fires. The channel does not set its raw bit again until software writes its arm bit to 1.
- R8: Writing 1 to bit c of the clear register (offset 0x24) clears raw bit c, and zero bits in that write have no effect. The clear register reads zero.
- R9: Masked status (offset 0x20) equals raw status AND enable (offset 0x18), and irq_o is high exactly when masked status is nonzero.
- R10: A channel whose arm bit is 0 never sets its raw status bit, even while its level matches its polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse every 1 ms that paces the filters |
| pin_i | input | 8 | Asynchronous external inputs, one per channel |
| reg_addr_i | input | 8 | Register byte address |
| reg_we_i | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Combined interrupt |

## Verification
A pin change needs two clock edges to cross the synchronizer. The bench therefore waits four cycles after each pin change before it pulses a tick. A filtered level updates on the edge that takes the completing tick, and the bench reads it several cycles later. Raw status, the arm clear and irq_o follow one edge after a level update or an arm write. A clear write takes effect on its own write edge. Every read drives the address at a falling edge and samples one time unit later, so each result is taken well after the edge it depends on.

// File: rtl/lib_pkg.sv
package lib_pkg;
    parameter int LIB_CH     = 8;
    parameter int LIB_WIN_W  = 12;
    parameter int LIB_BUS_W  = 32;
    parameter int LIB_ADDR_W = 8;
    parameter int LIB_SYNC_N = 2;

    // Register byte offsets
    localparam int OFS_LEVEL  = 'h00;
    localparam int OFS_SMPEN  = 'h04;
    localparam int OFS_POL    = 'h14;
    localparam int OFS_IE     = 'h18;
    localparam int OFS_RAW    = 'h1C;
    localparam int OFS_MASKED = 'h20;
    localparam int OFS_CLR    = 'h24;
    localparam int OFS_ARM    = 'h28;
    localparam int OFS_WIN    = 'h40;
    localparam int WIN_STRIDE = 4;

    typedef struct packed {
        logic [LIB_CH-1:0] smp_en;
        logic [LIB_CH-1:0] pol;
        logic [LIB_CH-1:0] ie;
    } lib_ctrl_t;

    function automatic int win_offset(input int ch);
        return OFS_WIN + WIN_STRIDE * ch;
    endfunction
endpackage

// File: rtl/lib_sync.sv
module lib_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) stg_q <= '0;
        else       stg_q <= {stg_q[STAGES-2:0], d_i};
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lib_debounce.sv
module lib_debounce #(
    parameter int WIN_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic             smp_i,
    input  logic [WIN_W-1:0] win_i,
    output logic             level_o
);
    logic [WIN_W-1:0] cnt_q;
    logic [WIN_W-1:0] lim;
    logic [WIN_W:0]   cnt_nxt;

    assign lim     = (win_i == '0) ? WIN_W'(1) : win_i;
    assign cnt_nxt = {1'b0, cnt_q} + 1'b1;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q   <= '0;
            level_o <= 1'b0;
        end else if (!en_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (smp_i == level_o) begin
                cnt_q <= '0;
            end else if (cnt_nxt >= {1'b0, lim}) begin
                level_o <= smp_i;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_nxt[WIN_W-1:0];
            end
        end
    end

    // R2
    level_moves_on_tick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(level_o) |-> $past(tick_i && en_i));

    // R4
    idle_count_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(!en_i) |-> (cnt_q == '0));
endmodule

// File: rtl/lib_irq_status.sv
module lib_irq_status #(
    parameter int N = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [N-1:0] level_i,
    input  logic [N-1:0] pol_i,
    input  logic [N-1:0] ie_i,
    input  logic         arm_we_i,
    input  logic [N-1:0] arm_wd_i,
    input  logic         clr_we_i,
    input  logic [N-1:0] clr_wd_i,
    output logic [N-1:0] raw_o,
    output logic [N-1:0] arm_o,
    output logic         irq_o
);
    logic [N-1:0] fire;
    logic [N-1:0] clr_mask;

    assign fire     = arm_o & ~(level_i ^ pol_i);
    assign clr_mask = clr_we_i ? clr_wd_i : '0;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            raw_o <= '0;
            arm_o <= '0;
        end else begin
            arm_o <= (arm_we_i ? arm_wd_i : arm_o) & ~fire;
            raw_o <= (raw_o & ~clr_mask) | fire;
        end
    end

    assign irq_o = |(raw_o & ie_i);

    // R9
    irq_needs_raw_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (raw_o == '0) |-> !irq_o);

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R10
        raw_needs_arm_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            $rose(raw_o[i]) |-> $past(arm_o[i]));
        // R7
        arm_drops_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            $rose(raw_o[i]) |-> !arm_o[i]);
        // R8
        clear_takes_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            $past(clr_we_i && clr_wd_i[i] && !fire[i]) |-> !raw_o[i]);
    end
endmodule

// File: rtl/lib_bank.sv
module lib_bank #(
    parameter int NUM_CH = lib_pkg::LIB_CH,
    parameter int WIN_W  = lib_pkg::LIB_WIN_W,
    parameter int BUS_W  = lib_pkg::LIB_BUS_W,
    parameter int ADDR_W = lib_pkg::LIB_ADDR_W,
    parameter int SYNC_N = lib_pkg::LIB_SYNC_N
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              tick_i,
    input  logic [NUM_CH-1:0] pin_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_we_i,
    input  logic [BUS_W-1:0]  reg_wdata_i,
    output logic [BUS_W-1:0]  reg_rdata_o,
    output logic              irq_o
);
    import lib_pkg::*;

    logic [NUM_CH-1:0]            smp_en_q, pol_q, ie_q;
    logic [NUM_CH-1:0][WIN_W-1:0] win_q;
    logic [NUM_CH-1:0]            pin_s, level, raw, arm, win_hit;
    logic                         arm_we, clr_we;
    logic                         unused_wdata;

    assign unused_wdata = ^reg_wdata_i[BUS_W-1:WIN_W];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
        assign win_hit[c] = (reg_addr_i == ADDR_W'(win_offset(c)));
    end

    // Control registers
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            smp_en_q <= '0;
            pol_q    <= '0;
            ie_q     <= '0;
            win_q    <= {NUM_CH{WIN_W'(1)}};
        end else if (reg_we_i) begin
            case (reg_addr_i)
                ADDR_W'(OFS_SMPEN): smp_en_q <= reg_wdata_i[NUM_CH-1:0];
                ADDR_W'(OFS_POL):   pol_q    <= reg_wdata_i[NUM_CH-1:0];
                ADDR_W'(OFS_IE):    ie_q     <= reg_wdata_i[NUM_CH-1:0];
                default: begin
                    for (int c = 0; c < NUM_CH; c++) begin
                        if (win_hit[c]) win_q[c] <= reg_wdata_i[WIN_W-1:0];
                    end
                end
            endcase
        end
    end

    assign arm_we = reg_we_i && (reg_addr_i == ADDR_W'(OFS_ARM));
    assign clr_we = reg_we_i && (reg_addr_i == ADDR_W'(OFS_CLR));

    lib_sync #(.W(NUM_CH), .STAGES(SYNC_N)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (pin_i),
        .q_o   (pin_s)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        lib_debounce #(.WIN_W(WIN_W)) u_dbn (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .tick_i  (tick_i),
            .en_i    (smp_en_q[c]),
            .smp_i   (pin_s[c]),
            .win_i   (win_q[c]),
            .level_o (level[c])
        );
    end

    lib_irq_status #(.N(NUM_CH)) u_stat (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .level_i  (level),
        .pol_i    (pol_q),
        .ie_i     (ie_q),
        .arm_we_i (arm_we),
        .arm_wd_i (reg_wdata_i[NUM_CH-1:0]),
        .clr_we_i (clr_we),
        .clr_wd_i (reg_wdata_i[NUM_CH-1:0]),
        .raw_o    (raw),
        .arm_o    (arm),
        .irq_o    (irq_o)
    );

    // Read mux
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADDR_W'(OFS_LEVEL):  reg_rdata_o = BUS_W'(level);
            ADDR_W'(OFS_SMPEN):  reg_rdata_o = BUS_W'(smp_en_q);
            ADDR_W'(OFS_POL):    reg_rdata_o = BUS_W'(pol_q);
            ADDR_W'(OFS_IE):     reg_rdata_o = BUS_W'(ie_q);
            ADDR_W'(OFS_RAW):    reg_rdata_o = BUS_W'(raw);
            ADDR_W'(OFS_MASKED): reg_rdata_o = BUS_W'(raw & ie_q);
            ADDR_W'(OFS_ARM):    reg_rdata_o = BUS_W'(arm);
            default: begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (win_hit[c]) reg_rdata_o = BUS_W'(win_q[c]);
                end
            end
        endcase
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk_i)
        $past(rst_i) |-> !irq_o);
endmodule

// File: tb/tb_lib_bank.sv
module tb_lib_bank;
    logic        clk = 1'b0;
    logic        rst;
    logic        tick;
    logic [7:0]  pins;
    logic [7:0]  addr;
    logic        we;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    lib_bank dut (
        .clk_i       (clk),
        .rst_i       (rst),
        .tick_i      (tick),
        .pin_i       (pins),
        .reg_addr_i  (addr),
        .reg_we_i    (we),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    typedef struct packed {
        logic [2:0]  ch;
        logic [11:0] win;
        logic        lvl;
        logic [3:0]  ticks;
        logic        expv;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd0, 12'd3, 1'b1, 4'd2, 1'b0},
        '{3'd0, 12'd3, 1'b1, 4'd1, 1'b1},
        '{3'd1, 12'd1, 1'b1, 4'd1, 1'b1},
        '{3'd2, 12'd0, 1'b1, 4'd1, 1'b1},
        '{3'd3, 12'd5, 1'b1, 4'd5, 1'b1},
        '{3'd0, 12'd3, 1'b0, 4'd3, 1'b0},
        '{3'd7, 12'd2, 1'b1, 4'd1, 1'b0},
        '{3'd7, 12'd2, 1'b1, 4'd1, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic set_pin(input int ch, input logic v);
        @(negedge clk);
        pins[ch] = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; tick = 1'b0; pins = '0; addr = '0; we = 1'b0; wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(8'h00, v); check("R1 level", v, 32'h0);
        rd(8'h04, v); check("R1 smpen", v, 32'h0);
        rd(8'h14, v); check("R1 pol", v, 32'h0);
        rd(8'h18, v); check("R1 ie", v, 32'h0);
        rd(8'h1C, v); check("R1 raw", v, 32'h0);
        rd(8'h20, v); check("R1 masked", v, 32'h0);
        rd(8'h28, v); check("R1 arm", v, 32'h0);
        rd(8'h40, v); check("R1 win0", v, 32'h1);
        check("R1 irq", {31'd0, irq}, 32'h0);

        // R2 and R5: vector table
        wr(8'h04, 32'hFF);
        for (int i = 0; i < 8; i++) begin
            wr(8'h40 + 8'(4 * VECS[i].ch), 32'(VECS[i].win));
            set_pin(int'(VECS[i].ch), VECS[i].lvl);
            ticks(int'(VECS[i].ticks));
            rd(8'h00, v);
            check($sformatf("R2 vec%0d", i), {31'd0, v[VECS[i].ch]}, {31'd0, VECS[i].expv});
        end
        rd(8'h00, v); check("R1 level upper bits", {24'd0, v[31:8]}, 32'h0);

        // R5: window readback keeps 12 bits
        wr(8'h50, 32'hFFFF_F123);
        rd(8'h50, v); check("R5 win mask", v, 32'h123);

        // R3: bounce restarts the count
        wr(8'h50, 32'd4);
        set_pin(4, 1'b1); ticks(3);
        set_pin(4, 1'b0); ticks(1);
        set_pin(4, 1'b1); ticks(3);
        rd(8'h00, v); check("R3 restarted", {31'd0, v[4]}, 32'h0);
        ticks(1);
        rd(8'h00, v); check("R3 accepted", {31'd0, v[4]}, 32'h1);

        // R4: sampling disabled
        wr(8'h04, 32'hDF);
        set_pin(5, 1'b1); ticks(3);
        rd(8'h00, v); check("R4 ignored", {31'd0, v[5]}, 32'h0);
        wr(8'h04, 32'hFF); ticks(1);
        rd(8'h00, v); check("R4 resumed", {31'd0, v[5]}, 32'h1);
        // levels now 0xBE

        // R10: unarmed channel 6 matches pol 0 but stays quiet
        rd(8'h1C, v); check("R10 unarmed", v, 32'h0);

        // R6 / R9 / R7
        wr(8'h18, 32'h40);
        wr(8'h28, 32'h40);
        rd(8'h1C, v); check("R6 low fire", v, 32'h40);
        rd(8'h20, v); check("R9 masked", v, 32'h40);
        check("R9 irq", {31'd0, irq}, 32'h1);
        rd(8'h28, v); check("R7 arm cleared", v, 32'h0);

        wr(8'h14, 32'h02);
        wr(8'h28, 32'h02);
        rd(8'h1C, v); check("R6 high fire", v, 32'h42);
        rd(8'h20, v); check("R9 masked only ie", v, 32'h40);

        wr(8'h14, 32'h03);
        wr(8'h28, 32'h01);
        rd(8'h1C, v); check("R6 mismatch quiet", v, 32'h42);
        rd(8'h28, v); check("R7 stays armed", v, 32'h1);
        set_pin(0, 1'b1); ticks(3);
        rd(8'h1C, v); check("R6 fire after level", v, 32'h43);
        rd(8'h28, v); check("R7 auto clear", v, 32'h0);

        // R8: clear
        wr(8'h24, 32'h02);
        rd(8'h1C, v); check("R8 clear one", v, 32'h41);
        wr(8'h24, 32'h00);
        rd(8'h1C, v); check("R8 zero write", v, 32'h41);
        rd(8'h24, v); check("R8 clr reads zero", v, 32'h0);
        wr(8'h24, 32'h40);
        rd(8'h1C, v); check("R7 no refire", v, 32'h01);
        rd(8'h20, v); check("R9 masked empty", v, 32'h0);
        check("R9 irq low", {31'd0, irq}, 32'h0);
        wr(8'h28, 32'h40);
        rd(8'h1C, v); check("R7 rearm", v, 32'h41);
        check("R9 irq again", {31'd0, irq}, 32'h1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule